// File: doc/BRIEF.md
# Multi-Queue Descriptor Queue Manager

This block keeps a bank of independent hardware FIFOs whose entries are 32-bit packet-descriptor addresses pointing into shared memory. Producers and consumers reach it through a plain 32-bit register bus with a write strobe and a separate read strobe, each with its own address, so a push and a pop can land in the same clock cycle. Writing the push/pop word of a queue appends the written address, and reading that same word removes and returns the oldest entry. A read of an empty queue returns an all-ones marker in place of an entry.

Separate address windows give a non-destructive look at the head of the low-numbered queues and the fill level of every queue, packed one byte per queue. A single shared clear word empties whichever queue number is written to it and leaves every other queue alone. Each queue is a 16-entry circular buffer with its own read pointer, write pointer and fill count. Per-queue empty, full and sticky overflow flags are driven out as vectors for use by neighbouring logic.

Read data is registered: `rd_data` and `rd_valid` show the result in the cycle after the one in which `rd_en` was high. Byte addresses must be word aligned; unaligned addresses count as unmapped.

Top module: `qmgr_desc_queues`

## Requirements
- R1: A write to byte address 0xD00 + 4*q (q from 0 to 63) appends `wr_data` to queue q. A read of that address removes the oldest entry and returns it, so entries come out in the order they went in. The result appears on `rd_data` with `rd_valid` high in the cycle after `rd_en`.
- R2: A pop from an empty queue returns 0xFFFFFFFF and leaves that queue's pointers and count unchanged.
- R3: Each queue holds at most 16 entries and its pointers wrap around. A push to a full queue, without a pop in the same cycle, is dropped and sets bit q of `q_overflow`. That bit stays set until the queue is cleared.
- R4: A read of 0xE00 + 4*q for q from 0 to 15 returns the head entry of queue q without removing it, or 0xFFFFFFFF if the queue is empty.
- R5: A read of 0xE40 + 4*w (w from 0 to 15) returns the fill counts of queues 4w to 4w+3. Queue 4w+k sits in bits [8k+7:8k], so the count of queue q is the byte at 0xE40 + q.
- R6: Writing a value n below 64 to 0xF40 empties queue n and clears its overflow bit, and all other queues keep their contents. Values of 64 or more have no effect.
- R7: When a push and a pop hit the same non-empty queue in one cycle, the pop returns the head, the pushed entry is appended and the count is unchanged. This holds even when the queue is full. If the queue is empty, the pop returns 0xFFFFFFFF and the pushed entry is kept.
- R8: `q_empty[q]` is high exactly when queue q holds no entry, and `q_full[q]` is high exactly when it holds 16.
- R9: Writes to the peek window, the count window or unmapped addresses change no queue. Reads of unmapped addresses return 0.
- R10: After reset every queue is empty and no overflow bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 12 | Write byte address |
| wr_data | input | 32 | Write data (descriptor address or queue number) |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 12 | Read byte address |
| rd_data | output | 32 | Read result, registered |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| q_empty | output | 64 | Per-queue empty flags |
| q_full | output | 64 | Per-queue full flags |
| q_overflow | output | 64 | Per-queue sticky overflow flags |

## Verification
The in-RTL properties watch every queue controller on every cycle. They check that the count never exceeds the depth, that a dropped push leaves the count alone and marks overflow, that overflow stays set until a clear, and that an empty pop moves no pointer. They also check that a clear empties the queue, that a paired push and pop keeps the count, and that every read strobe is answered one cycle later. Only the directed scenarios can show that data comes out in order and with the right values. The same applies to wrap-around after a full fill and drain, the byte packing of the count window, the head values seen through peek, the isolation of one queue from a clear of another, and that writes to read-only or unmapped addresses have no effect.

// File: rtl/qmgr_pkg.sv
package qmgr_pkg;

    // Address window a bus access falls into
    typedef enum logic [2:0] {
        WIN_NONE,
        WIN_QUEUE,
        WIN_PEEK,
        WIN_COUNT,
        WIN_CLEAR
    } win_e;

endpackage

// File: rtl/qmgr_addr_decode.sv
module qmgr_addr_decode
    import qmgr_pkg::*;
#(
    parameter int AW         = 12,
    parameter int NUM_Q      = 64,
    parameter int QW         = 6,
    parameter int QUEUE_BASE = 'hD00,
    parameter int PEEK_BASE  = 'hE00,
    parameter int CNT_BASE   = 'hE40,
    parameter int CLR_BASE   = 'hF40,
    parameter int PEEK_N     = 16,
    parameter int CNT_WORDS  = 16
) (
    input  logic [AW-1:0] addr,
    output win_e          win,
    output logic [QW-1:0] idx
);

    localparam int QUEUE_END = QUEUE_BASE + 4 * NUM_Q;
    localparam int PEEK_END  = PEEK_BASE + 4 * PEEK_N;
    localparam int CNT_END   = CNT_BASE + 4 * CNT_WORDS;

    int a;

    always_comb begin
        a   = int'(addr);
        win = WIN_NONE;
        idx = '0;
        if (addr[1:0] != 2'b00) begin
            win = WIN_NONE;
        end else if (a >= QUEUE_BASE && a < QUEUE_END) begin
            win = WIN_QUEUE;
            idx = QW'((a - QUEUE_BASE) >> 2);
        end else if (a >= PEEK_BASE && a < PEEK_END) begin
            win = WIN_PEEK;
            idx = QW'((a - PEEK_BASE) >> 2);
        end else if (a >= CNT_BASE && a < CNT_END) begin
            win = WIN_COUNT;
            idx = QW'((a - CNT_BASE) >> 2);
        end else if (a == CLR_BASE) begin
            win = WIN_CLEAR;
        end
    end

endmodule

// File: rtl/qmgr_queue_ctrl.sv
module qmgr_queue_ctrl #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          clear,
    output logic [PW-1:0] rptr,
    output logic [PW-1:0] wptr,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full,
    output logic          ovf,
    output logic          wr_ok
);

    logic pop_ok;
    logic push_ok;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign wr_ok   = push_ok && !clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else if (clear) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (push && !push_ok) ovf <= 1'b1;
        end
    end

    // R3: occupancy never exceeds the depth
    assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: a push into a full queue without a pop is dropped and flagged
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clear) |=> ($stable(count) && ovf));

    // R3: overflow is sticky until clear
    assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

    // R2: popping an empty queue moves nothing
    assert_empty_pop_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push && !clear) |=> ($stable(rptr) && $stable(wptr) && empty));

    // R6: a clear leaves the queue empty
    assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (empty && !ovf));

    // R7: paired push and pop on a non-empty queue keep the count
    assert_pushpop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !clear) |=> $stable(count));

endmodule

// File: rtl/qmgr_desc_queues.sv
module qmgr_desc_queues
    import qmgr_pkg::*;
#(
    parameter int NUM_Q      = 64,
    parameter int DEPTH      = 16,
    parameter int DW         = 32,
    parameter int AW         = 12,
    parameter int QUEUE_BASE = 'hD00,
    parameter int PEEK_BASE  = 'hE00,
    parameter int CNT_BASE   = 'hE40,
    parameter int CLR_BASE   = 'hF40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             rd_valid,
    output logic [NUM_Q-1:0] q_empty,
    output logic [NUM_Q-1:0] q_full,
    output logic [NUM_Q-1:0] q_overflow
);

    localparam int QW        = $clog2(NUM_Q);
    localparam int PW        = $clog2(DEPTH);
    localparam int CW        = $clog2(DEPTH + 1);
    localparam int CPW       = DW / 8;
    localparam int CNT_WORDS = NUM_Q / CPW;
    localparam int PEEK_N    = (CNT_BASE - PEEK_BASE) / 4;
    localparam int SLOTS     = NUM_Q * DEPTH;

    win_e          wwin;
    win_e          rwin;
    logic [QW-1:0] widx;
    logic [QW-1:0] ridx;

    qmgr_addr_decode #(
        .AW(AW), .NUM_Q(NUM_Q), .QW(QW),
        .QUEUE_BASE(QUEUE_BASE), .PEEK_BASE(PEEK_BASE),
        .CNT_BASE(CNT_BASE), .CLR_BASE(CLR_BASE),
        .PEEK_N(PEEK_N), .CNT_WORDS(CNT_WORDS)
    ) u_wdec (
        .addr(wr_addr), .win(wwin), .idx(widx)
    );

    qmgr_addr_decode #(
        .AW(AW), .NUM_Q(NUM_Q), .QW(QW),
        .QUEUE_BASE(QUEUE_BASE), .PEEK_BASE(PEEK_BASE),
        .CNT_BASE(CNT_BASE), .CLR_BASE(CLR_BASE),
        .PEEK_N(PEEK_N), .CNT_WORDS(CNT_WORDS)
    ) u_rdec (
        .addr(rd_addr), .win(rwin), .idx(ridx)
    );

    logic [PW-1:0]    rptr_a [NUM_Q];
    logic [PW-1:0]    wptr_a [NUM_Q];
    logic [CW-1:0]    cnt_a  [NUM_Q];
    logic [NUM_Q-1:0] wr_ok_v;
    logic [NUM_Q-1:0] push_v;
    logic [NUM_Q-1:0] pop_v;
    logic [NUM_Q-1:0] clr_v;

    for (genvar g = 0; g < NUM_Q; g++) begin : g_queue
        assign push_v[g] = wr_en && (wwin == WIN_QUEUE) && (widx == QW'(g));
        assign clr_v[g]  = wr_en && (wwin == WIN_CLEAR) && (wr_data == DW'(g));
        assign pop_v[g]  = rd_en && (rwin == WIN_QUEUE) && (ridx == QW'(g));

        qmgr_queue_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push_v[g]),
            .pop   (pop_v[g]),
            .clear (clr_v[g]),
            .rptr  (rptr_a[g]),
            .wptr  (wptr_a[g]),
            .count (cnt_a[g]),
            .empty (q_empty[g]),
            .full  (q_full[g]),
            .ovf   (q_overflow[g]),
            .wr_ok (wr_ok_v[g])
        );
    end

    // Entry storage: one flat array, queue number in the upper index bits
    logic [DW-1:0] store [SLOTS];

    always_ff @(posedge clk) begin
        if (|wr_ok_v) store[{widx, wptr_a[widx]}] <= wr_data;
    end

    // Read selection
    logic [DW-1:0] rval;
    logic [DW-1:0] head;

    assign head = (cnt_a[ridx] == '0) ? '1 : store[{ridx, rptr_a[ridx]}];

    always_comb begin
        rval = '0;
        unique case (rwin)
            WIN_QUEUE, WIN_PEEK: rval = head;
            WIN_COUNT: begin
                for (int k = 0; k < CPW; k++) begin
                    rval[8*k +: 8] = 8'(cnt_a[QW'(int'(ridx) * CPW + k)]);
                end
            end
            default: rval = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rval;
        end
    end

    // R1: every read strobe is answered in the next cycle
    assert_rd_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8: no queue is reported empty and full at once
    assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (q_empty & q_full) == '0);

endmodule

// File: tb/test_qmgr_desc_queues.sv
module test_qmgr_desc_queues;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic [63:0] q_empty;
    logic [63:0] q_full;
    logic [63:0] q_overflow;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;

    qmgr_desc_queues i_qmgr_desc_queues (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid),
        .q_empty(q_empty), .q_full(q_full), .q_overflow(q_overflow)
    );

    localparam logic [11:0] CLR = 12'hF40;

    function automatic logic [11:0] qa(int q); return 12'(12'hD00 + 4 * q); endfunction
    function automatic logic [11:0] pa(int q); return 12'(12'hE00 + 4 * q); endfunction
    function automatic logic [11:0] ca(int w); return 12'(12'hE40 + 4 * w); endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic bus_both(logic [11:0] wa, logic [31:0] wd, logic [11:0] ra,
                            output logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = wd;
        rd_en = 1'b1; rd_addr = ra;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        d = rd_data;
    endtask

    function automatic logic [7:0] cbyte(logic [31:0] w, int k);
        return w[8*k +: 8];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        chk("R10", "empty flags", q_empty, '1);
        chk("R10", "full flags", q_full, '0);
        chk("R10", "overflow flags", q_overflow, '0);
        bus_rd(qa(5), d);
        chk("R2", "pop empty q5", d, 32'hFFFF_FFFF);
        chk("R1", "rd_valid", rd_valid, 1'b1);
        bus_rd(ca(1), d);
        chk("R5", "counts q4..q7", d, 32'h0);
    endtask

    task automatic t_order();
        logic [31:0] d;
        bus_wr(qa(0), 32'hA000_0010);
        bus_wr(qa(0), 32'hA000_0020);
        bus_wr(qa(0), 32'hA000_0030);
        bus_rd(pa(0), d);
        chk("R4", "peek q0", d, 32'hA000_0010);
        bus_rd(ca(0), d);
        chk("R5", "count q0", cbyte(d, 0), 8'd3);
        chk("R8", "q0 not empty", q_empty[0], 1'b0);
        bus_rd(qa(0), d); chk("R1", "pop q0 #1", d, 32'hA000_0010);
        bus_rd(qa(0), d); chk("R1", "pop q0 #2", d, 32'hA000_0020);
        bus_rd(qa(0), d); chk("R1", "pop q0 #3", d, 32'hA000_0030);
        chk("R8", "q0 empty", q_empty[0], 1'b1);
        bus_rd(pa(2), d);
        chk("R4", "peek empty q2", d, 32'hFFFF_FFFF);
        bus_rd(qa(0), d);
        chk("R2", "pop drained q0", d, 32'hFFFF_FFFF);
        bus_wr(qa(0), 32'hA000_0040);
        bus_rd(qa(0), d);
        chk("R2", "pointers kept after empty pop", d, 32'hA000_0040);
    endtask

    task automatic t_full();
        logic [31:0] d;
        for (int i = 0; i < 17; i++) bus_wr(qa(3), 32'h3000 + i);
        chk("R8", "q3 full", q_full[3], 1'b1);
        chk("R3", "q3 overflow", q_overflow[3], 1'b1);
        chk("R3", "other overflow clear", q_overflow & ~(64'd1 << 3), '0);
        bus_rd(ca(0), d);
        chk("R5", "count q3 byte", cbyte(d, 3), 8'd16);
        bus_both(qa(3), 32'h3FFF, qa(3), d);
        chk("R7", "pop at full", d, 32'h3000);
        chk("R7", "still full", q_full[3], 1'b1);
        for (int i = 1; i < 16; i++) begin
            bus_rd(qa(3), d);
            chk("R3", "drain q3", d, 32'h3000 + i);
        end
        bus_rd(qa(3), d);
        chk("R7", "pushed-at-full entry", d, 32'h3FFF);
        chk("R8", "q3 empty", q_empty[3], 1'b1);
        bus_wr(qa(3), 32'h3ABC);
        bus_rd(qa(3), d);
        chk("R3", "wrap-around", d, 32'h3ABC);
        chk("R3", "overflow sticky", q_overflow[3], 1'b1);
        bus_wr(CLR, 32'd3);
        chk("R6", "overflow cleared", q_overflow[3], 1'b0);
    endtask

    task automatic t_pushpop();
        logic [31:0] d;
        bus_wr(qa(9), 32'h9001);
        bus_wr(qa(9), 32'h9002);
        bus_both(qa(9), 32'h9003, qa(9), d);
        chk("R7", "pop during push", d, 32'h9001);
        bus_rd(ca(2), d);
        chk("R7", "q9 count kept", cbyte(d, 1), 8'd2);
        bus_rd(qa(9), d); chk("R7", "q9 next", d, 32'h9002);
        bus_rd(qa(9), d); chk("R7", "q9 last", d, 32'h9003);
        bus_both(qa(10), 32'hA0A0, qa(10), d);
        chk("R7", "empty pop during push", d, 32'hFFFF_FFFF);
        bus_rd(qa(10), d);
        chk("R7", "push kept on empty", d, 32'hA0A0);
    endtask

    task automatic t_clear_ignore();
        logic [31:0] d;
        bus_wr(qa(1), 32'h55);
        bus_wr(qa(17), 32'h1717);
        bus_wr(qa(63), 32'h6363);
        bus_wr(pa(1), 32'h0);
        bus_wr(ca(0), 32'h0);
        bus_wr(12'h004, 32'h0);
        bus_wr(12'hD02, 32'h77);
        bus_rd(pa(1), d);
        chk("R9", "peek q1 after stray writes", d, 32'h55);
        bus_rd(ca(0), d);
        chk("R9", "count q1 after stray writes", cbyte(d, 1), 8'd1);
        bus_rd(12'h004, d);
        chk("R9", "unmapped read", d, 32'h0);
        bus_wr(CLR, 32'd64);
        bus_rd(ca(0), d);
        chk("R6", "clear 64 ignored", cbyte(d, 1), 8'd1);
        bus_wr(CLR, 32'd17);
        chk("R6", "q17 empty", q_empty[17], 1'b1);
        bus_rd(ca(15), d);
        chk("R6", "q63 untouched", cbyte(d, 3), 8'd1);
        bus_rd(qa(17), d);
        chk("R6", "pop cleared q17", d, 32'hFFFF_FFFF);
        bus_rd(qa(63), d);
        chk("R6", "pop q63", d, 32'h6363);
        bus_rd(qa(1), d);
        chk("R1", "pop q1", d, 32'h55);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full();
        t_pushpop();
        t_clear_ignore();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule